// File: doc/BRIEF.md
# Queued Serial Transmit FIFO

This block is the transmit queue in front of a synchronous serial shift engine. Software loads each entry in two steps. It first sets a chip-select code in a small register. It then writes the transmit data, either as one 16-bit word or as two byte writes. The high byte is held in a staging register. The write of the low byte, or the word write, is the commit that pushes an entry holding the chip-select code and the data, and advances the write pointer.

The shift engine reads the entry at the head of the queue. When it finishes a transfer it pulses a done strobe, which frees that slot and advances the read pointer. Empty and full flags come from an occupancy counter. A cleared empty flag is the engine's cue to start. A commit that finds the queue full is dropped, and the block raises a one-cycle overflow interrupt. A synchronous pointer clear returns the queue to the empty state.

Top module: `serq_tx_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `rd_ptr` is 0 and `ovf_irq` is 0.
- R2: A commit (`lo_we` or `word_we`) into a non-full queue stores an entry and clears `empty` from the next cycle on. `head_entry` presents the oldest entry, with the chip-select code in bits 19:16 and the data in bits 15:0.
- R3: A word write (`word_we`) commits `wdata[15:0]` as the entry data in a single cycle.
- R4: A high-byte write (`hi_we`) stages `wdata[7:0]` and does not push an entry; `empty` is unchanged. A following low-byte write (`lo_we`) commits `{staged byte, wdata[7:0]}`.
- R5: While `len8` is 1, the upper 8 data bits of any committed entry are stored as 0.
- R6: `full` becomes 1 after 16 commits following a reset or pointer clear with no transfer done, and `empty` is then 0.
- R7: A `xfer_done` pulse on a non-empty queue advances `rd_ptr` by one, modulo 16, and frees the head slot. On an empty queue it has no effect.
- R8: A commit while the queue is full, without `xfer_done` in the same cycle, stores nothing and leaves the stored entries intact. `ovf_irq` is 1 for exactly the cycle after it.
- R9: A commit together with `xfer_done` on a full queue is accepted. `full` stays 1, `rd_ptr` advances and no overflow is raised.
- R10: `ptr_clr` clears both pointers, the occupancy and the staged byte. `empty` becomes 1, `full` becomes 0, and a later lone `lo_we` commits a high byte of 0.
- R11: An entry may be committed without any chip-select write; after reset its chip-select field is 0. The entry uses the chip-select register value held before the commit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_clr | input | 1 | Synchronous pointer and occupancy clear |
| cs_we | input | 1 | Write the chip-select register |
| cs_wdata | input | 4 | Chip-select code to hold |
| hi_we | input | 1 | Stage the high data byte from wdata[7:0] |
| lo_we | input | 1 | Low-byte commit from wdata[7:0] |
| word_we | input | 1 | Full-word commit from wdata[15:0] |
| wdata | input | 16 | CPU write data |
| len8 | input | 1 | 8-bit transfer length: zero the upper data byte |
| xfer_done | input | 1 | Serial engine finished the head entry |
| head_entry | output | 20 | Entry at the read pointer {cs, data} |
| rd_ptr | output | 4 | Current read pointer |
| empty | output | 1 | Queue holds no entry |
| full | output | 1 | Queue holds 16 entries |
| ovf_irq | output | 1 | One-cycle pulse after a rejected commit |

## Verification
The bench builds the block with its default parameters: 16 entries, 16 data bits and a 4-bit chip-select code. At that depth the queue can be filled to full in a few dozen cycles. Overflow, the simultaneous commit and done on a full queue, and a complete drain with every rd_ptr value and both wraps are all reachable. Each entry gets distinct data and chip-select values, so a dropped or overwritten slot shows up in head_entry.

// File: rtl/serq_pkg.sv
package serq_pkg;
  typedef enum logic [1:0] {
    CK_NONE = 2'd0,
    CK_LO   = 2'd1,
    CK_WORD = 2'd2
  } commit_kind_t;
endpackage

// File: rtl/serq_stage.sv
module serq_stage #(
  parameter int DW  = 16,
  parameter int CSW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cs_we,
  input  logic [CSW-1:0]     cs_wdata,
  input  logic               hi_we,
  input  logic               lo_we,
  input  logic               word_we,
  input  logic [DW-1:0]      wdata,
  input  logic               len8,
  output logic               commit,
  output logic [CSW+DW-1:0]  entry
);
  import serq_pkg::*;
  localparam int HB = DW / 2;

  logic [HB-1:0]  stage_q;
  logic [CSW-1:0] cs_q;
  commit_kind_t   kind;

  function automatic logic [DW-1:0] build_data(
    input commit_kind_t k, input logic l8,
    input logic [DW-1:0] w, input logic [HB-1:0] st);
    logic [DW-1:0] d;
    if (k == CK_WORD) d = w;
    else              d = {st, w[HB-1:0]};
    if (l8) d[DW-1:HB] = '0;
    return d;
  endfunction

  always_comb begin
    if (word_we)     kind = CK_WORD;
    else if (lo_we)  kind = CK_LO;
    else             kind = CK_NONE;
  end

  assign commit = (kind != CK_NONE);
  assign entry  = {cs_q, build_data(kind, len8, wdata, stage_q)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      cs_q    <= '0;
    end else begin
      if (cs_we) cs_q <= cs_wdata;
      if (clr)        stage_q <= '0;
      else if (hi_we) stage_q <= wdata[HB-1:0];
    end
  end

  // R4
  staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_we && !clr) |=> $stable(stage_q));
endmodule

// File: rtl/serq_ptrs.sv
module serq_ptrs #(
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      commit,
  input  logic                      done,
  output logic                      accept,
  output logic                      pop,
  output logic                      ovf_set,
  output logic [$clog2(DEPTH)-1:0]  wr_ptr,
  output logic [$clog2(DEPTH)-1:0]  rd_ptr,
  output logic                      empty,
  output logic                      full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] occ_next(
    input logic [CW-1:0] c, input logic up, input logic dn);
    if (up && !dn) return c + 1'b1;
    if (dn && !up) return c - 1'b1;
    return c;
  endfunction

  assign empty   = (count_q == '0);
  assign full    = (count_q == FULL_CNT);
  assign pop     = done && !empty && !clr;
  assign accept  = commit && !clr && (!full || pop);
  assign ovf_set = commit && !clr && full && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else if (clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (accept) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)    rd_ptr <= ptr_inc(rd_ptr);
      count_q <= occ_next(count_q, accept, pop);
    end
  end

  // R6
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  // R7
  rd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> rd_ptr == ptr_inc($past(rd_ptr)));
  // R8
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !done && !clr) |=> $stable(wr_ptr) && full);
  // R10
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty && rd_ptr == '0 && wr_ptr == '0);
endmodule

// File: rtl/serq_store.sv
module serq_store #(
  parameter int DEPTH = 16,
  parameter int EW    = 20
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [EW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [EW-1:0]            rdata
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/serq_tx_fifo.sv
module serq_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int CSW   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ptr_clr,
  input  logic                     cs_we,
  input  logic [CSW-1:0]           cs_wdata,
  input  logic                     hi_we,
  input  logic                     lo_we,
  input  logic                     word_we,
  input  logic [DW-1:0]            wdata,
  input  logic                     len8,
  input  logic                     xfer_done,
  output logic [CSW+DW-1:0]        head_entry,
  output logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic                     empty,
  output logic                     full,
  output logic                     ovf_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = CSW + DW;

  logic          commit_w;
  logic          accept_w;
  logic          pop_w;
  logic          ovf_set_w;
  logic [EW-1:0] entry_w;
  logic [AW-1:0] wr_ptr_w;

  serq_stage #(.DW(DW), .CSW(CSW)) u_stage (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr),
    .cs_we(cs_we), .cs_wdata(cs_wdata),
    .hi_we(hi_we), .lo_we(lo_we), .word_we(word_we),
    .wdata(wdata), .len8(len8),
    .commit(commit_w), .entry(entry_w)
  );

  serq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr),
    .commit(commit_w), .done(xfer_done),
    .accept(accept_w), .pop(pop_w), .ovf_set(ovf_set_w),
    .wr_ptr(wr_ptr_w), .rd_ptr(rd_ptr),
    .empty(empty), .full(full)
  );

  serq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .we(accept_w), .waddr(wr_ptr_w), .wdata(entry_w),
    .raddr(rd_ptr), .rdata(head_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_irq <= 1'b0;
    else        ovf_irq <= ovf_set_w;
  end

  // R8
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_w && full && !xfer_done && !ptr_clr) |=> ovf_irq);
  // R9
  both_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_w && xfer_done && full && !ptr_clr) |=> full && !ovf_irq);
  // R2
  commit_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !ptr_clr) |=> !empty);
endmodule

// File: tb/tb_serq_tx_fifo.sv
module tb_serq_tx_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_clr = 1'b0;
  logic        cs_we = 1'b0;
  logic [3:0]  cs_wdata = '0;
  logic        hi_we = 1'b0;
  logic        lo_we = 1'b0;
  logic        word_we = 1'b0;
  logic [15:0] wdata = '0;
  logic        len8 = 1'b0;
  logic        xfer_done = 1'b0;
  logic [19:0] head_entry;
  logic [3:0]  rd_ptr;
  logic        empty;
  logic        full;
  logic        ovf_irq;

  int n_checks = 0;
  int n_fail = 0;

  serq_tx_fifo dut (
    .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr),
    .cs_we(cs_we), .cs_wdata(cs_wdata),
    .hi_we(hi_we), .lo_we(lo_we), .word_we(word_we),
    .wdata(wdata), .len8(len8), .xfer_done(xfer_done),
    .head_entry(head_entry), .rd_ptr(rd_ptr),
    .empty(empty), .full(full), .ovf_irq(ovf_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // one-cycle strobes applied after a negedge, released at the next negedge
  task automatic set_cs(input logic [3:0] c);
    cs_we = 1'b1; cs_wdata = c;
    @(negedge clk); cs_we = 1'b0;
  endtask
  task automatic wr_word(input logic [15:0] d);
    word_we = 1'b1; wdata = d;
    @(negedge clk); word_we = 1'b0;
  endtask
  task automatic wr_hi(input logic [7:0] b);
    hi_we = 1'b1; wdata = {8'h00, b};
    @(negedge clk); hi_we = 1'b0;
  endtask
  task automatic wr_lo(input logic [7:0] b);
    lo_we = 1'b1; wdata = {8'h00, b};
    @(negedge clk); lo_we = 1'b0;
  endtask
  task automatic done1();
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask
  task automatic clear();
    ptr_clr = 1'b1;
    @(negedge clk); ptr_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 rd_ptr", rd_ptr, 0);
    check("R1 ovf", ovf_irq, 0);
  endtask

  task automatic t_slave();
    wr_word(16'h1234);
    check("R11 cs zero", head_entry, 20'h01234);
    check("R2 not empty", empty, 0);
    clear();
  endtask

  task automatic t_word_bytes();
    set_cs(4'h5);
    wr_word(16'hA1B2);
    check("R3 head", head_entry, 20'h5A1B2);
    wr_hi(8'h3C);
    check("R4 hi no push", rd_ptr, 0);
    wr_lo(8'h4D);
    done1();
    check("R7 rd_ptr", rd_ptr, 1);
    check("R4 byte pair", head_entry, 20'h53C4D);
    done1();
    check("R7 empty", empty, 1);
    done1();
    check("R7 done on empty", rd_ptr, 2);
    check("R7 still empty", empty, 1);
    clear();
    wr_hi(8'h99);
    check("R4 hi keeps empty", empty, 1);
    clear();
    wr_lo(8'h42);
    check("R10 stage cleared", head_entry, 20'h50042);
    clear();
  endtask

  task automatic t_len8();
    len8 = 1'b1;
    set_cs(4'h2);
    wr_word(16'hFFEE);
    check("R5 word len8", head_entry, 20'h200EE);
    wr_hi(8'hAB);
    wr_lo(8'h77);
    done1();
    check("R5 byte len8", head_entry, 20'h20077);
    len8 = 1'b0;
    clear();
  endtask

  task automatic t_fill_ovf();
    for (int i = 0; i < 16; i++) begin
      set_cs(4'(i));
      wr_word(16'h1000 + 16'(i));
      check("R6 not full early", full, (i == 15) ? 1 : 0);
    end
    check("R6 empty low", empty, 0);
    set_cs(4'hF);
    wr_word(16'hDEAD);
    check("R8 ovf pulse", ovf_irq, 1);
    idle();
    check("R8 ovf one cycle", ovf_irq, 0);
    check("R8 still full", full, 1);
    // R9: commit and done together while full
    word_we = 1'b1; wdata = 16'hBEEF; xfer_done = 1'b1;
    @(negedge clk); word_we = 1'b0; xfer_done = 1'b0;
    check("R9 full kept", full, 1);
    check("R9 no ovf", ovf_irq, 0);
    check("R9 rd adv", rd_ptr, 1);
    for (int i = 1; i < 16; i++) begin
      check("R8 drain data", head_entry, {4'(i), 16'h1000 + 16'(i)});
      done1();
    end
    check("R9 new entry", head_entry, 20'hFBEEF);
    check("R7 wrap", rd_ptr, 0);
    done1();
    check("R7 drained", empty, 1);
    wr_word(16'h0001);
    clear();
    check("R10 empty", empty, 1);
    check("R10 rd_ptr", rd_ptr, 0);
    check("R10 full", full, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_slave();
    t_word_bytes();
    t_len8();
    t_fill_ovf();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule